// File: doc/BRIEF.md
# Counted-Burst SPI Master

This block is an SPI master that clocks one counted burst of 8-bit frames. Software loads bytes into a transmit queue and programs two counts: the total number of frames in the burst, and how many of those frames take their byte from the queue. Frames beyond the data count are sent as zero bytes, which suits command-then-read exchanges where the tail of the burst only clocks in a reply. Received bytes are stored in a receive queue unless the discard control is set.

The serial clock advances one half period for each pulse on `sck_tick`, so the bit rate is set outside the block. The control word selects clock polarity, clock phase and bit order. Four chip-select lines are driven either automatically (the selected line is active while a burst runs) or by a manual level, and the inactive level of every line is programmable. A sticky transfer-complete flag, cleared by writing one, drives `irq` through an enable bit.

Registers are 32-bit words on a simple synchronous bus. They are addressed by word index: 0 TXQ (write pushes a byte), 1 RXQ (read pops a byte), 2 CTRL, 3 IRQEN, 4 IRQST, 5 NFRAMES, 6 NDATA, 7 FILL. Read data appears on `bus_rdata` one cycle after `bus_rd`.

Top module: `spi_burst_engine`

## Requirements
- R1: After reset, CTRL reads 0x10 (inactive chip-select level high), IRQST and FILL read 0, all four `cs_line` outputs are 1, `sck` is 0 and `irq` is 0.
- R2: Writing CTRL with bit 10 set while idle, with NFRAMES (bits 23:0) equal to N>0, clocks N frames of 8 bits, each bit taking two `sck_tick` pulses. CTRL bit 10 reads 1 during the burst and 0 after it, and IRQST bit 16 is set when the last frame ends.
- R3: CTRL bit 3 sets the idle level of `sck`. CTRL bit 2 clear means `mosi` changes on the trailing edge and is sampled on the leading edge; set means it changes on the leading edge and is sampled on the trailing edge. CTRL bit 6 set shifts the least significant bit first, clear the most significant bit first.
- R4: With NDATA (bits 23:0) equal to T, frames 0..T-1 carry TXQ bytes in push order, and an empty queue yields 0x00. Frames T and later carry 0x00 and leave the queue untouched.
- R5: While CTRL bit 15 is set, received frames are not stored, and the receive fill level stays unchanged.
- R6: Each received byte is stored in order. Reading RXQ returns the oldest byte in bits 7:0 and removes it. Reading an empty RXQ returns 0.
- R7: Both queues hold 64 bytes. FILL reports the receive level in bits 6:0 and the transmit level in bits 22:16. A TXQ write to a full queue is dropped.
- R8: A CTRL write with bit 8 set empties the transmit queue, and one with bit 9 set empties the receive queue. Each leaves the other queue unchanged.
- R9: IRQST bit 16 stays set until a write with bit 16 set clears it, and writing 0 leaves it set. `irq` is high only while that flag and IRQEN bit 16 are both set, with a delay of one cycle.
- R10: CTRL bits 13:12 pick one of four lines. Unselected lines sit at the inactive level (CTRL bit 4). In automatic mode (bit 16 clear) the selected line takes the opposite level during a burst. In manual mode (bit 16 set) it follows CTRL bit 17.
- R11: While a burst runs, CTRL writes do not change bits 2, 3, 6 or 15.
- R12: Starting with NFRAMES equal to 0 clocks no frame and sets IRQST bit 16 at once.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_wr | input | 1 | Register write strobe |
| bus_rd | input | 1 | Register read strobe |
| bus_addr | input | 4 | Register word index |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, valid one cycle after bus_rd |
| sck_tick | input | 1 | Half-period strobe for the serial clock |
| miso | input | 1 | Serial data in |
| sck | output | 1 | Serial clock |
| mosi | output | 1 | Serial data out |
| cs_line | output | 4 | Chip-select lines |
| irq | output | 1 | Transfer-complete interrupt |

## Verification
A wrong frame or bit counter shows at the ports at once: the byte captured from `mosi` in the frame where it goes wrong has shifted bits, and the burst ends with too few or too many frames. A wrong edge choice or bit order corrupts the first frame. A queue pointer or level error shows at the next FILL read or RXQ pop, and a data-count error shows as a nonzero transmit level after the burst. Chip-select and interrupt state are registered, so their errors reach the pins within one cycle.

// File: rtl/spi_burst_pkg.sv
package spi_burst_pkg;
  typedef enum logic [3:0] {
    A_TXQ = 4'd0, A_RXQ = 4'd1, A_CTRL = 4'd2, A_IRQEN = 4'd3,
    A_IRQST = 4'd4, A_NFRAMES = 4'd5, A_NDATA = 4'd6, A_FILL = 4'd7
  } reg_addr_e;

  localparam int C_PHASE   = 2;
  localparam int C_POL     = 3;
  localparam int C_IDLEHI  = 4;
  localparam int C_LSB     = 6;
  localparam int C_TXCLR   = 8;
  localparam int C_RXCLR   = 9;
  localparam int C_GO      = 10;
  localparam int C_SEL     = 12;
  localparam int C_DROP    = 15;
  localparam int C_MAN     = 16;
  localparam int C_LVL     = 17;
  localparam int IRQ_BIT   = 16;
  localparam int TXLVL_POS = 16;

  typedef struct packed {
    logic cpol;
    logic cpha;
    logic lsb;
    logic discard;
  } mode_t;
endpackage

// File: rtl/spi_burst_fifo.sv
module spi_burst_fifo #(
  parameter int W     = 8,
  parameter int DEPTH = 64,
  localparam int AW   = $clog2(DEPTH),
  localparam int LW   = AW + 1
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          clr,
  input  logic          push,
  input  logic [W-1:0]  wdata,
  input  logic          pop,
  output logic [W-1:0]  head,
  output logic [LW-1:0] level,
  output logic          full,
  output logic          empty
);
  logic [W-1:0]  mem [DEPTH];
  logic [AW-1:0] wptr, rptr;
  logic          do_push, do_pop;

  assign full    = (level == LW'(DEPTH));
  assign empty   = (level == '0);
  assign do_push = push & ~full & ~clr;
  assign do_pop  = pop & ~empty & ~clr;
  assign head    = mem[rptr];

  always_ff @(posedge clk) begin
    if (do_push) mem[wptr] <= wdata;
  end

  always_ff @(posedge clk) begin
    if (rst || clr) begin
      wptr  <= '0;
      rptr  <= '0;
      level <= '0;
    end else begin
      if (do_push) wptr <= wptr + AW'(1);
      if (do_pop)  rptr <= rptr + AW'(1);
      case ({do_push, do_pop})
        2'b10:   level <= level + LW'(1);
        2'b01:   level <= level - LW'(1);
        default: level <= level;
      endcase
    end
  end
endmodule

// File: rtl/spi_burst_shift.sv
module spi_burst_shift
  import spi_burst_pkg::*;
#(
  parameter int CW  = 24,
  parameter int FW  = 8,
  localparam int BW = $clog2(FW),
  localparam int HW = BW + 1
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          start,
  input  mode_t         mode,
  input  logic [CW-1:0] burst_len,
  input  logic [CW-1:0] data_len,
  input  logic          tick,
  input  logic          miso,
  input  logic [FW-1:0] tx_head,
  input  logic          tx_empty,
  output logic          tx_pop,
  output logic          rx_push,
  output logic [FW-1:0] rx_byte,
  output logic          sck,
  output logic          mosi,
  output logic          busy,
  output logic          done
);
  logic          run;
  logic [CW-1:0] frame_idx, next_idx;
  logic [HW-1:0] half;
  logic [BW-1:0] bit_idx;
  logic [FW-1:0] txb, rxb, rx_next, load_byte;
  logic          lead, trail, last, samp, more, load, use_q;

  function automatic logic [BW-1:0] bitpos(logic [BW-1:0] b, logic lsb);
    return lsb ? b : (BW'(FW - 1) - b);
  endfunction

  assign bit_idx = half[HW-1:1];
  assign lead    = tick & run & ~half[0];
  assign trail   = tick & run & half[0];
  assign last    = trail & (half == HW'(2 * FW - 1));
  assign samp    = mode.cpha ? trail : lead;
  assign more    = (frame_idx + CW'(1)) < burst_len;
  assign next_idx = start ? '0 : frame_idx + CW'(1);
  assign load    = (start & (burst_len != '0)) | (last & more);
  assign use_q   = load & (next_idx < data_len);
  assign tx_pop  = use_q & ~tx_empty;
  assign load_byte = tx_pop ? tx_head : '0;

  always_comb begin
    rx_next = rxb;
    if (samp) rx_next[bitpos(bit_idx, mode.lsb)] = miso;
  end

  assign rx_push = last & ~mode.discard;
  assign rx_byte = rx_next;
  assign busy    = run;

  always_ff @(posedge clk) begin
    if (rst) begin
      run       <= 1'b0;
      done      <= 1'b0;
      frame_idx <= '0;
      half      <= '0;
      txb       <= '0;
      rxb       <= '0;
      sck       <= 1'b0;
      mosi      <= 1'b0;
    end else begin
      done <= 1'b0;
      if (start) begin
        sck <= mode.cpol;
        if (burst_len == '0) begin
          done <= 1'b1;
        end else begin
          run       <= 1'b1;
          frame_idx <= '0;
          half      <= '0;
          txb       <= load_byte;
          rxb       <= '0;
          if (!mode.cpha) mosi <= load_byte[bitpos('0, mode.lsb)];
        end
      end else if (run) begin
        if (tick) begin
          sck  <= ~sck;
          half <= half + HW'(1);
          rxb  <= rx_next;
          if (lead && mode.cpha) mosi <= txb[bitpos(bit_idx, mode.lsb)];
          if (trail) begin
            if (last) begin
              if (more) begin
                frame_idx <= next_idx;
                txb       <= load_byte;
                rxb       <= '0;
                if (!mode.cpha) mosi <= load_byte[bitpos('0, mode.lsb)];
              end else begin
                run  <= 1'b0;
                done <= 1'b1;
              end
            end else if (!mode.cpha) begin
              mosi <= txb[bitpos(bit_idx + BW'(1), mode.lsb)];
            end
          end
        end
      end else begin
        sck <= mode.cpol;
      end
    end
  end
endmodule

// File: rtl/spi_burst_engine.sv
module spi_burst_engine
  import spi_burst_pkg::*;
#(
  parameter int DEPTH = 64,
  parameter int CW    = 24,
  parameter int FW    = 8,
  parameter int NCS   = 4,
  parameter int DW    = 32,
  parameter int AW    = 4,
  localparam int LW   = $clog2(DEPTH) + 1,
  localparam int SW   = $clog2(NCS)
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          bus_wr,
  input  logic          bus_rd,
  input  logic [AW-1:0] bus_addr,
  input  logic [DW-1:0] bus_wdata,
  output logic [DW-1:0] bus_rdata,
  input  logic          sck_tick,
  input  logic          miso,
  output logic          sck,
  output logic          mosi,
  output logic [NCS-1:0] cs_line,
  output logic          irq
);
  mode_t         mode_q, mode_in, mode_eff;
  logic          idle_hi_q, cs_man_q, cs_lvl_q, ien_q, tc_q;
  logic [SW-1:0] cs_sel_q;
  logic [CW-1:0] nframes_q, ndata_q;

  logic          wr_ctrl, start, tx_clr, rx_clr, busy, eng_done;
  logic          tx_push, tx_pop, tx_full, tx_empty;
  logic          rx_push, rx_pop, rx_full, rx_empty;
  logic [FW-1:0] tx_head, rx_head, rx_byte;
  logic [LW-1:0] tx_level, rx_level;
  logic [DW-1:0] rd_val;

  assign wr_ctrl = bus_wr && (bus_addr == AW'(A_CTRL));
  assign start   = wr_ctrl & bus_wdata[C_GO] & ~busy;
  assign tx_clr  = wr_ctrl & bus_wdata[C_TXCLR];
  assign rx_clr  = wr_ctrl & bus_wdata[C_RXCLR];
  assign tx_push = bus_wr && (bus_addr == AW'(A_TXQ));
  assign rx_pop  = bus_rd && (bus_addr == AW'(A_RXQ));

  assign mode_in  = '{cpol: bus_wdata[C_POL], cpha: bus_wdata[C_PHASE],
                      lsb: bus_wdata[C_LSB], discard: bus_wdata[C_DROP]};
  assign mode_eff = (wr_ctrl && !busy) ? mode_in : mode_q;

  spi_burst_fifo #(.W(FW), .DEPTH(DEPTH)) tx_q_i (
    .clk(clk), .rst(rst), .clr(tx_clr), .push(tx_push), .wdata(bus_wdata[FW-1:0]),
    .pop(tx_pop), .head(tx_head), .level(tx_level), .full(tx_full), .empty(tx_empty)
  );

  spi_burst_fifo #(.W(FW), .DEPTH(DEPTH)) rx_q_i (
    .clk(clk), .rst(rst), .clr(rx_clr), .push(rx_push), .wdata(rx_byte),
    .pop(rx_pop), .head(rx_head), .level(rx_level), .full(rx_full), .empty(rx_empty)
  );

  spi_burst_shift #(.CW(CW), .FW(FW)) shift_i (
    .clk(clk), .rst(rst), .start(start), .mode(mode_eff),
    .burst_len(nframes_q), .data_len(ndata_q), .tick(sck_tick), .miso(miso),
    .tx_head(tx_head), .tx_empty(tx_empty), .tx_pop(tx_pop),
    .rx_push(rx_push), .rx_byte(rx_byte), .sck(sck), .mosi(mosi),
    .busy(busy), .done(eng_done)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      mode_q    <= '0;
      idle_hi_q <= 1'b1;
      cs_sel_q  <= '0;
      cs_man_q  <= 1'b0;
      cs_lvl_q  <= 1'b0;
      ien_q     <= 1'b0;
      tc_q      <= 1'b0;
      nframes_q <= '0;
      ndata_q   <= '0;
    end else begin
      if (wr_ctrl) begin
        if (!busy) mode_q <= mode_in;
        idle_hi_q <= bus_wdata[C_IDLEHI];
        cs_sel_q  <= bus_wdata[C_SEL +: SW];
        cs_man_q  <= bus_wdata[C_MAN];
        cs_lvl_q  <= bus_wdata[C_LVL];
      end
      if (bus_wr && bus_addr == AW'(A_IRQEN))   ien_q     <= bus_wdata[IRQ_BIT];
      if (bus_wr && bus_addr == AW'(A_NFRAMES)) nframes_q <= bus_wdata[CW-1:0];
      if (bus_wr && bus_addr == AW'(A_NDATA))   ndata_q   <= bus_wdata[CW-1:0];
      if (eng_done)
        tc_q <= 1'b1;
      else if (bus_wr && bus_addr == AW'(A_IRQST) && bus_wdata[IRQ_BIT])
        tc_q <= 1'b0;
    end
  end

  always_comb begin
    rd_val = '0;
    case (bus_addr)
      AW'(A_RXQ):     rd_val[FW-1:0] = rx_empty ? '0 : rx_head;
      AW'(A_CTRL): begin
        rd_val[C_PHASE]     = mode_q.cpha;
        rd_val[C_POL]       = mode_q.cpol;
        rd_val[C_IDLEHI]    = idle_hi_q;
        rd_val[C_LSB]       = mode_q.lsb;
        rd_val[C_GO]        = busy;
        rd_val[C_SEL +: SW] = cs_sel_q;
        rd_val[C_DROP]      = mode_q.discard;
        rd_val[C_MAN]       = cs_man_q;
        rd_val[C_LVL]       = cs_lvl_q;
      end
      AW'(A_IRQEN):   rd_val[IRQ_BIT] = ien_q;
      AW'(A_IRQST):   rd_val[IRQ_BIT] = tc_q;
      AW'(A_NFRAMES): rd_val[CW-1:0]  = nframes_q;
      AW'(A_NDATA):   rd_val[CW-1:0]  = ndata_q;
      AW'(A_FILL): begin
        rd_val[LW-1:0]            = rx_level;
        rd_val[TXLVL_POS +: LW]   = tx_level;
      end
      default:        rd_val = '0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      bus_rdata <= '0;
      irq       <= 1'b0;
    end else begin
      if (bus_rd) bus_rdata <= rd_val;
      irq <= tc_q & ien_q;
    end
  end

  for (genvar i = 0; i < NCS; i++) begin : g_cs
    always_ff @(posedge clk) begin
      if (rst)
        cs_line[i] <= 1'b1;
      else if (cs_sel_q == SW'(i))
        cs_line[i] <= cs_man_q ? cs_lvl_q : (busy ? ~idle_hi_q : idle_hi_q);
      else
        cs_line[i] <= idle_hi_q;
    end
  end

  logic unused_bits;
  assign unused_bits = ^{1'b0, bus_wdata[DW-1:CW], rx_full, tx_full};
endmodule

// File: rtl/spi_burst_chk.sv
module spi_burst_chk #(
  parameter int DEPTH = 64,
  parameter int NCS   = 4,
  parameter int LW    = 7
) (
  input logic           clk,
  input logic           rst,
  input logic           busy,
  input logic           done,
  input logic           sck,
  input logic [3:0]     mode_bits,
  input logic           irq,
  input logic           tc,
  input logic           ien,
  input logic [NCS-1:0] cs_line,
  input logic           idle_hi,
  input logic [LW-1:0]  tx_level,
  input logic [LW-1:0]  rx_level,
  input logic           rx_push
);
  AST_SCK_PARKED: assert property (@(posedge clk) disable iff (rst)
    (!busy && !$past(busy) && $stable(mode_bits[3])) |-> (sck == mode_bits[3])); // R3
  AST_DONE_IDLE: assert property (@(posedge clk) disable iff (rst)
    done |-> !busy); // R2
  AST_FIFO_CAP: assert property (@(posedge clk) disable iff (rst)
    (tx_level <= LW'(DEPTH)) && (rx_level <= LW'(DEPTH))); // R7
  AST_DISCARD_NOPUSH: assert property (@(posedge clk) disable iff (rst)
    (busy && mode_bits[0]) |-> !rx_push); // R5
  AST_IRQ_GATED: assert property (@(posedge clk) disable iff (rst)
    irq |-> $past(tc && ien)); // R9
  AST_CS_SINGLE: assert property (@(posedge clk) disable iff (rst)
    1'b1 |=> ($countones(cs_line ^ {NCS{$past(idle_hi)}}) <= 1)); // R10
  AST_MODE_FROZEN: assert property (@(posedge clk) disable iff (rst)
    (busy && $past(busy)) |-> $stable(mode_bits)); // R11
endmodule

bind spi_burst_engine spi_burst_chk #(.DEPTH(DEPTH), .NCS(NCS), .LW(LW)) chk_i (
  .clk(clk), .rst(rst), .busy(busy), .done(eng_done), .sck(sck),
  .mode_bits(mode_q), .irq(irq), .tc(tc_q), .ien(ien_q), .cs_line(cs_line),
  .idle_hi(idle_hi_q), .tx_level(tx_level), .rx_level(rx_level), .rx_push(rx_push)
);

// File: tb/spi_burst_engine_tb_top.sv
module spi_burst_engine_tb_top;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        bus_wr = 1'b0, bus_rd = 1'b0;
  logic [3:0]  bus_addr = '0;
  logic [31:0] bus_wdata = '0;
  logic [31:0] bus_rdata;
  logic        sck_tick = 1'b0;
  logic        sck, mosi, irq;
  logic [3:0]  cs_line;
  logic        miso;

  assign miso = mosi;

  spi_burst_engine dut_i (
    .clk(clk), .rst(rst), .bus_wr(bus_wr), .bus_rd(bus_rd), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .sck_tick(sck_tick), .miso(miso),
    .sck(sck), .mosi(mosi), .cs_line(cs_line), .irq(irq)
  );

  always #4 clk = ~clk;

  int n_chk = 0, n_fail = 0;

  // vector: {cpol, cpha, lsb, discard, frames[7:0], data_frames[7:0], seed[7:0]}
  localparam int NV = 6;
  localparam logic [27:0] VEC [NV] = '{
    {4'b0000, 8'd4,  8'd4,  8'h11},
    {4'b0100, 8'd3,  8'd3,  8'hA5},
    {4'b1010, 8'd5,  8'd2,  8'h3C},
    {4'b1110, 8'd2,  8'd2,  8'h81},
    {4'b0011, 8'd3,  8'd3,  8'h5A},
    {4'b1000, 8'd64, 8'd64, 8'h07}
  };

  // serial-line monitor
  bit          mon_en = 0, m_cpol = 0, m_cpha = 0, m_lsb = 0;
  logic        sck_prev = 1'b0;
  logic [7:0]  sh = '0;
  int          nb = 0, cap_n = 0;
  logic [7:0]  cap [512];
  logic [7:0]  exp_b [128];

  always @(negedge clk) begin
    if (mon_en && sck !== sck_prev) begin
      if ((sck != m_cpol) != m_cpha) begin
        sh = m_lsb ? {mosi, sh[7:1]} : {sh[6:0], mosi};
        nb = nb + 1;
        if (nb == 8) begin
          cap[cap_n % 512] = sh;
          cap_n = cap_n + 1;
          nb = 0;
        end
      end
    end
    if (!mon_en) nb = 0;
    sck_prev = sck;
  end

  initial begin
    forever begin
      @(negedge clk);
      sck_tick = ~sck_tick;
    end
  end

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [3:0] a, input logic [31:0] d);
    @(negedge clk);
    bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
    @(negedge clk);
    bus_wr = 1'b0;
  endtask

  task automatic rd(input logic [3:0] a, output logic [31:0] d);
    @(negedge clk);
    bus_rd = 1'b1; bus_addr = a;
    @(negedge clk);
    bus_rd = 1'b0;
    d = bus_rdata;
  endtask

  task automatic finish_run;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  endtask

  function automatic logic [31:0] mk_ctrl(bit cpol, bit cpha, bit lsb, bit disc);
    return 32'h10 | (32'(cpol) << 3) | (32'(cpha) << 2) | (32'(lsb) << 6) | (32'(disc) << 15);
  endfunction

  task automatic wait_tc;
    logic [31:0] v;
    for (int k = 0; k < 5000; k++) begin
      rd(4'd4, v);
      if (v[16]) return;
    end
  endtask

  // sets counts and mode, runs the burst, optionally flips CPOL mid-burst
  task automatic run_burst(input bit cpol, input bit cpha, input bit lsb, input bit disc,
                           input int nfr, input int ndat, input bit poke, output int base);
    logic [31:0] c;
    c = mk_ctrl(cpol, cpha, lsb, disc);
    wr(4'd5, 32'(nfr));
    wr(4'd6, 32'(ndat));
    wr(4'd2, c);
    m_cpol = cpol; m_cpha = cpha; m_lsb = lsb;
    repeat (3) @(negedge clk);
    base = cap_n;
    mon_en = 1;
    wr(4'd2, c | 32'h400);
    if (poke) begin
      repeat (20) @(negedge clk);
      wr(4'd2, c ^ 32'h8048);
    end
    wait_tc();
    repeat (2) @(negedge clk);
    mon_en = 0;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    n_chk++; n_fail++;
    $display("FAIL watchdog: actual hung expected done");
    finish_run();
  end

  initial begin
    logic [31:0] v;
    int base;
    repeat (4) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);

    // reset state
    rd(4'd2, v); chk("R1 ctrl", v, 32'h10);
    rd(4'd4, v); chk("R1 irqst", v, 0);
    rd(4'd7, v); chk("R1 fill", v, 0);
    chk("R1 cs", 32'(cs_line), 32'hF);
    chk("R1 sck", 32'(sck), 0);
    chk("R1 irq", 32'(irq), 0);

    // vector table
    for (int vi = 0; vi < NV; vi++) begin
      logic [27:0] e;
      int nfr, ndat;
      e = VEC[vi];
      nfr = int'(e[23:16]); ndat = int'(e[15:8]);
      wr(4'd2, 32'h310);
      for (int i = 0; i < nfr; i++)
        exp_b[i] = (i < ndat) ? (e[7:0] + 8'(i * 29)) : 8'h00;
      for (int i = 0; i < ndat; i++) wr(4'd0, 32'(exp_b[i]));
      run_burst(e[27], e[26], e[25], e[24], nfr, ndat, 0, base);
      chk("R2 frame count", 32'(cap_n - base), 32'(nfr));
      for (int i = 0; i < nfr; i++)
        chk("R3 R4 frame byte", 32'(cap[(base + i) % 512]), 32'(exp_b[i]));
      rd(4'd2, v); chk("R2 go bit clear", 32'(v[10]), 0);
      rd(4'd7, v);
      chk("R4 tx drained", 32'(v[22:16]), 0);
      if (e[24]) chk("R5 discard level", 32'(v[6:0]), 0);
      else begin
        chk("R6 rx level", 32'(v[6:0]), 32'(nfr));
        for (int i = 0; i < nfr; i++) begin
          rd(4'd1, v);
          chk("R6 rx byte", v, 32'(exp_b[i]));
        end
      end
      wr(4'd4, 32'h1_0000);
    end

    // R12: zero-length burst
    wr(4'd5, 0);
    wr(4'd2, 32'h410);
    rd(4'd4, v); chk("R12 tc on zero burst", v, 32'h1_0000);
    rd(4'd2, v); chk("R12 not busy", 32'(v[10]), 0);

    // R9: sticky flag, enable gating, write-one-to-clear
    @(negedge clk); chk("R9 irq masked", 32'(irq), 0);
    wr(4'd4, 0);
    rd(4'd4, v); chk("R9 write zero keeps", v, 32'h1_0000);
    wr(4'd3, 32'h1_0000);
    @(negedge clk); chk("R9 irq on", 32'(irq), 1);
    wr(4'd4, 32'h1_0000);
    @(negedge clk); chk("R9 irq off", 32'(irq), 0);
    rd(4'd4, v); chk("R9 cleared", v, 0);
    wr(4'd3, 0);

    // R6: pop of empty receive queue
    wr(4'd2, 32'h310);
    rd(4'd1, v); chk("R6 empty pop", v, 0);

    // R7: full transmit queue drops
    for (int i = 0; i < 65; i++) wr(4'd0, 32'(i));
    rd(4'd7, v); chk("R7 tx level saturates", 32'(v[22:16]), 64);

    // R8: queue resets are independent
    wr(4'd2, 32'h110);
    for (int i = 0; i < 3; i++) begin
      exp_b[i] = 8'hC0 + 8'(i);
      wr(4'd0, 32'(exp_b[i]));
    end
    run_burst(0, 0, 0, 0, 2, 2, 0, base);
    rd(4'd7, v); chk("R8 levels before clear", v, 32'h0001_0002);
    wr(4'd2, 32'h210);
    rd(4'd7, v); chk("R8 rx cleared only", v, 32'h0001_0000);
    wr(4'd2, 32'h110);
    rd(4'd7, v); chk("R8 tx cleared", v, 0);
    wr(4'd4, 32'h1_0000);

    // R10: chip select
    wr(4'd2, 32'h2010);
    @(negedge clk); chk("R10 idle auto", 32'(cs_line), 32'hF);
    wr(4'd5, 2); wr(4'd6, 0);
    wr(4'd2, 32'h2410);
    repeat (6) @(negedge clk);
    chk("R10 active during burst", 32'(cs_line), 32'b1011);
    wait_tc();
    wr(4'd4, 32'h1_0000);
    wr(4'd2, 32'h1_1010);
    @(negedge clk); chk("R10 manual low", 32'(cs_line), 32'b1101);
    wr(4'd2, 32'h3_1010);
    @(negedge clk); chk("R10 manual high", 32'(cs_line), 32'hF);
    wr(4'd2, 32'h0000);
    @(negedge clk); chk("R10 idle low", 32'(cs_line), 32'h0);

    // R11: mode writes ignored while busy
    wr(4'd2, 32'h310);
    exp_b[0] = 8'h96; exp_b[1] = 8'h2B;
    wr(4'd0, 32'h96); wr(4'd0, 32'h2B);
    run_burst(0, 0, 0, 0, 2, 2, 1, base);
    rd(4'd2, v); chk("R11 mode kept", v & 32'h804C, 0);
    chk("R11 bytes intact 0", 32'(cap[base % 512]), 32'h96);
    chk("R11 bytes intact 1", 32'(cap[(base + 1) % 512]), 32'h2B);

    finish_run();
  end
endmodule